// File: doc/BRIEF.md
# NAND Flash Host Register Front End

This block sits between a processor-side register bus and the pins of an 8-bit NAND flash device. Software programs the device by writing command bytes, address bytes and data bytes into separate registers. Each of those writes becomes a tagged entry in a small write queue. A strobe sequencer drains the queue in order. It raises the command latch or address latch enable for command and address entries, drives the byte onto the flash data pins and pulses the write strobe low.

Reading is a two-step exchange. Software writes any value to a read-request register, and this places a read entry in the same queue. When that entry reaches the sequencer, the read strobe is pulsed and the byte on the flash data pins is latched into a read-data register. An interrupt-status flag then reports that the byte is ready. Software clears that flag by writing 1 to it.

The block also tracks page-transfer progress. It carries status and sticky event flags covering the queue level, overflow, queue drain and the device ready/busy line. Two programmable fields set the widths of the read and write strobes.

Top module: `nfc_host_regs`

## Requirements
- R1: After reset the status register (offset 1) reads 0x11 when the ready/busy input is high: bit 4 (queue empty) and bit 0 (not busy) are set. The interrupt-status register (offset 2) reads 0. Both strobes are high, and both latch enables and the data-pin drive enable are low.
- R2: A write to offset 3 (command) queues one command cycle, and a write to offset 4 (address) queues one address cycle. For a command cycle the command latch enable is high; for an address cycle the address latch enable is high. The byte is driven on the data pins while the write strobe is low for (write delay + 1) clocks, followed by one hold clock before the next cycle.
- R3: A write to offset 5 (write data) queues one data cycle. Queued cycles of all types reach the flash pins in the order the host wrote them.
- R4: A write of any value to offset 6 (read request) queues one read cycle, and the written value is not used. The read strobe is low for (read delay + 1) clocks. The byte present on the flash data input at the last strobe clock appears at offset 7 (read data), and interrupt-status bit 3 sets.
- R5: The queue holds DEPTH entries, and status bit 1 reports that it is full. A queueing write made while the queue is full is dropped and sets interrupt-status bit 1.
- R6: Interrupt-status bit 2 sets when the queue goes from holding entries to empty.
- R7: Status bit 0 follows the ready/busy input through a two-flop synchronizer. Interrupt-status bit 0 sets on a rising edge of the synchronized level.
- R8: Writing interrupt-status clears exactly the bits written as 1 and leaves bits written as 0 unchanged. A flag that sets in the same cycle as it is cleared stays set.
- R9: In the page control register (offset 8), writing bit 1 sets status bit 2 (page write pending) and writing bit 0 sets status bit 3 (page read pending). Page write pending clears after PAGE_BYTES data cycles complete and then sets interrupt-status bit 4. Page read pending clears after PAGE_BYTES read cycles complete.
- R10: Writing 1 to bit 0 of offset 9 (reset) clears the page transfer counters. That bit reads back as 1 during the clock after the write and as 0 afterwards.
- R11: The control register (offset 0) holds the write delay in bits [3:0] and the read delay in bits [7:4], and it reads back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Host access valid |
| bus_ready | output | 1 | Access accepted (always high) |
| bus_write | input | 1 | 1 = write access |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| nd_cle | output | 1 | Command latch enable |
| nd_ale | output | 1 | Address latch enable |
| nd_we_n | output | 1 | Write strobe, active low |
| nd_re_n | output | 1 | Read strobe, active low |
| nd_oe | output | 1 | Data pin drive enable |
| nd_dout | output | 8 | Data to flash |
| nd_din | input | 8 | Data from flash |
| nd_rb | input | 1 | Ready/busy, high = ready |

## Verification
The bench builds the block with DEPTH 4, PAGE_BYTES 3 and 4-bit delay fields. The three-byte page lets a test complete a page, clear the counters partway through a page and read both pending bits within a few dozen clocks. Setting the write delay to its maximum of 15 stretches each cycle enough that back-to-back host writes fill the queue, which makes the full bit, the overflow drop and the ordering of the surviving entries observable.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    CYC_CMD  = 2'd0,
    CYC_ADDR = 2'd1,
    CYC_DATA = 2'd2,
    CYC_READ = 2'd3
  } cyc_e;

  typedef struct packed {
    cyc_e              kind;
    logic [BYTE_W-1:0] data;
  } wb_entry_t;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_STROBE = 2'd1,
    SQ_HOLD   = 2'd2
  } sq_e;

  localparam logic [3:0] REG_CTRL = 4'd0;
  localparam logic [3:0] REG_STAT = 4'd1;
  localparam logic [3:0] REG_IST  = 4'd2;
  localparam logic [3:0] REG_CMD  = 4'd3;
  localparam logic [3:0] REG_ADR  = 4'd4;
  localparam logic [3:0] REG_WDAT = 4'd5;
  localparam logic [3:0] REG_RREQ = 4'd6;
  localparam logic [3:0] REG_RDAT = 4'd7;
  localparam logic [3:0] REG_PAGE = 4'd8;
  localparam logic [3:0] REG_RST  = 4'd9;
endpackage

// File: rtl/nfc_wbuf.sv
module nfc_wbuf
  import nfc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  wb_entry_t din,
  input  logic      pop,
  output wb_entry_t head,
  output logic      empty,
  output logic      full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  wb_entry_t         mem_q [DEPTH];
  logic [PW-1:0]     wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              do_push, do_pop;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign head  = mem_q[rp_q];

  always_comb begin
    do_push = push && !full;
    do_pop  = pop && !empty;
    wp_d    = wp_q;
    rp_d    = rp_q;
    if (do_push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= din;
  end

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_full_no_growth_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/nfc_strobe.sv
module nfc_strobe
  import nfc_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             avail,
  input  wb_entry_t        head,
  input  logic [DLY_W-1:0] wr_dly,
  input  logic [DLY_W-1:0] rd_dly,
  input  logic [7:0]       nd_din,
  output logic             pop,
  output logic             done,
  output cyc_e             done_kind,
  output logic [7:0]       rd_byte,
  output logic             nd_cle,
  output logic             nd_ale,
  output logic             nd_we_n,
  output logic             nd_re_n,
  output logic             nd_oe,
  output logic [7:0]       nd_dout
);
  sq_e              st_q, st_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  wb_entry_t        cur_q;
  logic [7:0]       rb_q;
  logic             cap_en;
  logic             busy;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    pop    = 1'b0;
    done   = 1'b0;
    cap_en = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (avail) begin
          pop   = 1'b1;
          st_d  = SQ_STROBE;
          cnt_d = (head.kind == CYC_READ) ? rd_dly : wr_dly;
        end
      end
      SQ_STROBE: begin
        if (cnt_q == '0) begin
          done   = 1'b1;
          st_d   = SQ_HOLD;
          cap_en = (cur_q.kind == CYC_READ);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      cur_q <= '0;
      rb_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (pop)    cur_q <= head;
      if (cap_en) rb_q  <= nd_din;
    end
  end

  assign busy      = (st_q != SQ_IDLE);
  assign done_kind = cur_q.kind;
  assign rd_byte   = rb_q;
  assign nd_cle    = busy && (cur_q.kind == CYC_CMD);
  assign nd_ale    = busy && (cur_q.kind == CYC_ADDR);
  assign nd_oe     = busy && (cur_q.kind != CYC_READ);
  assign nd_we_n   = !((st_q == SQ_STROBE) && (cur_q.kind != CYC_READ));
  assign nd_re_n   = !((st_q == SQ_STROBE) && (cur_q.kind == CYC_READ));
  assign nd_dout   = cur_q.data;

  p_strobe_end_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_STROBE && cnt_q == '0) |=> (st_q == SQ_HOLD));
  p_hold_one_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_HOLD) |=> (st_q == SQ_IDLE));
endmodule

// File: rtl/nfc_host_regs.sv
module nfc_host_regs
  import nfc_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int PAGE_BYTES = 512,
  parameter int DLY_W      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_valid,
  output logic       bus_ready,
  input  logic       bus_write,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       nd_cle,
  output logic       nd_ale,
  output logic       nd_we_n,
  output logic       nd_re_n,
  output logic       nd_oe,
  output logic [7:0] nd_dout,
  input  logic [7:0] nd_din,
  input  logic       nd_rb
);
  localparam int CTL_W = 2 * DLY_W;
  localparam int PCW   = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;

  logic             is_w;
  logic             sel_ctrl, sel_ist, sel_page, sel_rst;
  logic             push;
  wb_entry_t        push_e, head_e;
  logic             wb_empty, wb_full, sq_pop, sq_done;
  cyc_e             sq_kind;
  logic [7:0]       rd_byte;

  logic [CTL_W-1:0] ctrl_q;
  logic [4:0]       ist_q, ist_d, ist_set;
  logic             rb_s1_q, rb_s2_q, rb_s3_q, was_empty_q;
  logic             rst_pend_q;
  logic             wr_pend_q, wr_pend_d, rd_pend_q, rd_pend_d;
  logic [PCW-1:0]   wcnt_q, wcnt_d, rcnt_q, rcnt_d;
  logic             wr_hit, wr_last, rd_hit, rd_last;

  assign bus_ready = 1'b1;

  always_comb begin
    is_w     = bus_valid && bus_write;
    sel_ctrl = is_w && (bus_addr == REG_CTRL);
    sel_ist  = is_w && (bus_addr == REG_IST);
    sel_page = is_w && (bus_addr == REG_PAGE);
    sel_rst  = is_w && (bus_addr == REG_RST);
    push     = is_w && ((bus_addr == REG_CMD) || (bus_addr == REG_ADR) ||
                        (bus_addr == REG_WDAT) || (bus_addr == REG_RREQ));
    push_e.data = bus_wdata;
    case (bus_addr)
      REG_CMD:  push_e.kind = CYC_CMD;
      REG_ADR:  push_e.kind = CYC_ADDR;
      REG_WDAT: push_e.kind = CYC_DATA;
      default:  push_e.kind = CYC_READ;
    endcase
  end

  nfc_wbuf #(.DEPTH(DEPTH)) u_wbuf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (push_e),
    .pop   (sq_pop),
    .head  (head_e),
    .empty (wb_empty),
    .full  (wb_full)
  );

  nfc_strobe #(.DLY_W(DLY_W)) u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .avail     (!wb_empty),
    .head      (head_e),
    .wr_dly    (ctrl_q[DLY_W-1:0]),
    .rd_dly    (ctrl_q[CTL_W-1:DLY_W]),
    .nd_din    (nd_din),
    .pop       (sq_pop),
    .done      (sq_done),
    .done_kind (sq_kind),
    .rd_byte   (rd_byte),
    .nd_cle    (nd_cle),
    .nd_ale    (nd_ale),
    .nd_we_n   (nd_we_n),
    .nd_re_n   (nd_re_n),
    .nd_oe     (nd_oe),
    .nd_dout   (nd_dout)
  );

  // Page progress: counted only while pending, cleared by the reset register
  always_comb begin
    wr_hit  = sq_done && (sq_kind == CYC_DATA) && wr_pend_q && !rst_pend_q;
    rd_hit  = sq_done && (sq_kind == CYC_READ) && rd_pend_q && !rst_pend_q;
    wr_last = wr_hit && (wcnt_q == PCW'(PAGE_BYTES - 1));
    rd_last = rd_hit && (rcnt_q == PCW'(PAGE_BYTES - 1));

    if (rst_pend_q || wr_last) wcnt_d = '0;
    else if (wr_hit)           wcnt_d = wcnt_q + 1'b1;
    else                       wcnt_d = wcnt_q;
    if (rst_pend_q || rd_last) rcnt_d = '0;
    else if (rd_hit)           rcnt_d = rcnt_q + 1'b1;
    else                       rcnt_d = rcnt_q;

    wr_pend_d = (sel_page && bus_wdata[1]) ? 1'b1 : (wr_last ? 1'b0 : wr_pend_q);
    rd_pend_d = (sel_page && bus_wdata[0]) ? 1'b1 : (rd_last ? 1'b0 : rd_pend_q);
  end

  // Sticky event flags: write-1-to-clear, a new event wins
  always_comb begin
    ist_set    = '0;
    ist_set[0] = rb_s2_q && !rb_s3_q;
    ist_set[1] = push && wb_full;
    ist_set[2] = wb_empty && !was_empty_q;
    ist_set[3] = sq_done && (sq_kind == CYC_READ);
    ist_set[4] = wr_last;
    ist_d      = (sel_ist ? (ist_q & ~bus_wdata[4:0]) : ist_q) | ist_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      ist_q       <= '0;
      rb_s1_q     <= 1'b1;
      rb_s2_q     <= 1'b1;
      rb_s3_q     <= 1'b1;
      was_empty_q <= 1'b1;
      rst_pend_q  <= 1'b0;
      wr_pend_q   <= 1'b0;
      rd_pend_q   <= 1'b0;
      wcnt_q      <= '0;
      rcnt_q      <= '0;
    end else begin
      if (sel_ctrl) ctrl_q <= bus_wdata[CTL_W-1:0];
      ist_q       <= ist_d;
      rb_s1_q     <= nd_rb;
      rb_s2_q     <= rb_s1_q;
      rb_s3_q     <= rb_s2_q;
      was_empty_q <= wb_empty;
      rst_pend_q  <= sel_rst && bus_wdata[0];
      wr_pend_q   <= wr_pend_d;
      rd_pend_q   <= rd_pend_d;
      wcnt_q      <= wcnt_d;
      rcnt_q      <= rcnt_d;
    end
  end

  always_comb begin
    case (bus_addr)
      REG_CTRL: bus_rdata = 8'(ctrl_q);
      REG_STAT: bus_rdata = {3'b000, wb_empty, rd_pend_q, wr_pend_q, wb_full, rb_s2_q};
      REG_IST:  bus_rdata = {3'b000, ist_q};
      REG_RDAT: bus_rdata = rd_byte;
      REG_RST:  bus_rdata = {7'b0, rst_pend_q};
      default:  bus_rdata = 8'h00;
    endcase
  end

  p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sq_pop |-> !wb_empty);
  p_rdrdy_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ist_q[3]) |-> $past(sq_done && (sq_kind == CYC_READ)));
  p_nb_event_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ist_q[0]) |-> $past(rb_s2_q));
  p_counter_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_pend_q) |-> (wcnt_q == '0 && rcnt_q == '0));
  p_ovf_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ist_q[1]) |-> $past(wb_full));
endmodule

// File: tb/nfc_host_regs_bench.sv
module nfc_host_regs_bench;
  import nfc_pkg::*;

  localparam int DEPTH = 4;
  localparam int PB    = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_valid, bus_write, bus_ready;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       nd_cle, nd_ale, nd_we_n, nd_re_n, nd_oe, nd_rb;
  logic [7:0] nd_dout, nd_din;

  always #10 clk = ~clk;

  nfc_host_regs #(.DEPTH(DEPTH), .PAGE_BYTES(PB), .DLY_W(4)) u_nfc_host_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .nd_cle(nd_cle), .nd_ale(nd_ale), .nd_we_n(nd_we_n),
    .nd_re_n(nd_re_n), .nd_oe(nd_oe), .nd_dout(nd_dout), .nd_din(nd_din),
    .nd_rb(nd_rb)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // behavioural reference model
  int       q[$];
  int       mst, mcnt, mcur, mwcnt, mrcnt;
  bit [7:0] mctrl, mrdata;
  bit [4:0] mflags, setf;
  bit       mwpend, mrpend, mrst, ms1, ms2, ms3, mwas_empty;
  bit       m_wr, m_done, m_prerst;
  int       m_pre_sz, m_dk, m_kind;

  // strobe monitor
  int obs[$];
  int we_run = 0, re_run = 0, last_we_len = 0, last_re_len = 0;
  bit prev_we = 1, prev_re = 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mreg(input logic [3:0] a);
    case (a)
      REG_CTRL: return mctrl;
      REG_STAT: return {3'b000, q.size() == 0, mrpend, mwpend, q.size() == DEPTH, ms2};
      REG_IST:  return {3'b000, mflags};
      REG_RDAT: return mrdata;
      REG_RST:  return {7'b0, mrst};
      default:  return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); mst = 0; mcnt = 0; mcur = 0; mwcnt = 0; mrcnt = 0;
      mctrl = 0; mrdata = 0; mflags = 0; mwpend = 0; mrpend = 0; mrst = 0;
      ms1 = 1; ms2 = 1; ms3 = 1; mwas_empty = 1;
    end else begin
      m_wr = bus_valid && bus_write;
      m_pre_sz = q.size();
      m_done = 0; m_dk = 0; setf = 0;
      case (mst)
        0: if (m_pre_sz > 0) begin
             mcur = q.pop_front(); mst = 1;
             mcnt = ((mcur >> 8) == 3) ? int'(mctrl[7:4]) : int'(mctrl[3:0]);
           end
        1: if (mcnt == 0) begin
             mst = 2; m_done = 1; m_dk = mcur >> 8;
             if (m_dk == 3) mrdata = nd_din;
           end else mcnt--;
        default: mst = 0;
      endcase
      if (m_wr && (bus_addr == REG_CMD || bus_addr == REG_ADR ||
                   bus_addr == REG_WDAT || bus_addr == REG_RREQ)) begin
        m_kind = (bus_addr == REG_CMD) ? 0 : (bus_addr == REG_ADR) ? 1 :
                 (bus_addr == REG_WDAT) ? 2 : 3;
        if (m_pre_sz == DEPTH) setf[1] = 1;
        else q.push_back(m_kind * 256 + int'(bus_wdata));
      end
      if (m_pre_sz == 0 && !mwas_empty) setf[2] = 1;
      mwas_empty = (m_pre_sz == 0);
      if (ms2 && !ms3) setf[0] = 1;
      ms3 = ms2; ms2 = ms1; ms1 = nd_rb;
      if (m_done && m_dk == 3) setf[3] = 1;
      m_prerst = mrst;
      if (m_prerst) begin
        mwcnt = 0; mrcnt = 0;
      end else if (m_done) begin
        if (m_dk == 2 && mwpend) begin
          if (mwcnt == PB - 1) begin mwcnt = 0; mwpend = 0; setf[4] = 1; end
          else mwcnt++;
        end
        if (m_dk == 3 && mrpend) begin
          if (mrcnt == PB - 1) begin mrcnt = 0; mrpend = 0; end
          else mrcnt++;
        end
      end
      if (m_wr && bus_addr == REG_PAGE) begin
        if (bus_wdata[0]) mrpend = 1;
        if (bus_wdata[1]) mwpend = 1;
      end
      mrst = m_wr && bus_addr == REG_RST && bus_wdata[0];
      if (m_wr && bus_addr == REG_IST) mflags = mflags & ~bus_wdata[4:0];
      mflags = mflags | setf;
      if (m_wr && bus_addr == REG_CTRL) mctrl = bus_wdata;
    end
  end

  // pin comparison against the model every clock, plus strobe monitor
  always @(negedge clk) begin
    if (rst_n) begin
      logic exp_we, exp_re, exp_cle, exp_ale, exp_oe;
      int k;
      k = mcur >> 8;
      exp_we  = !(mst == 1 && k != 3);
      exp_re  = !(mst == 1 && k == 3);
      exp_cle = (mst != 0) && k == 0;
      exp_ale = (mst != 0) && k == 1;
      exp_oe  = (mst != 0) && k != 3;
      check("R2 R4 pins vs model", {nd_we_n, nd_re_n, nd_cle, nd_ale, nd_oe},
            {exp_we, exp_re, exp_cle, exp_ale, exp_oe});
      if (nd_oe) check("R3 dout vs model", nd_dout, mcur & 255);
      if (!nd_we_n) begin
        if (prev_we) obs.push_back({nd_cle, nd_ale, nd_dout});
        we_run++;
      end else if (!prev_we) begin
        last_we_len = we_run; we_run = 0;
      end
      if (!nd_re_n) re_run++;
      else if (!prev_re) begin last_re_len = re_run; re_run = 0; end
      prev_we = nd_we_n;
      prev_re = nd_re_n;
    end
  end

  task automatic hwrite(input logic [3:0] a, input logic [7:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic hread(input logic [3:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
    check("model register read", v, mreg(a));
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q.size() != 0 || mst != 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 0; bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
    nd_din = 8'h00; nd_rb = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    hread(REG_STAT, v); check("R1 status after reset", v, 8'h11);
    hread(REG_IST, v);  check("R1 flags after reset", v, 8'h00);
    check("R1 idle pins", {nd_we_n, nd_re_n, nd_cle, nd_ale, nd_oe}, 5'b11000);

    // R11 control fields
    hwrite(REG_CTRL, 8'h21);
    hread(REG_CTRL, v); check("R11 control readback", v, 8'h21);

    // R2 command and address cycles
    hwrite(REG_CMD, 8'h70); wait_idle();
    check("R2 command strobe width", last_we_len, 2);
    check("R2 command cycle", obs.pop_front(), 32'h270);
    hwrite(REG_ADR, 8'h05); wait_idle();
    check("R2 address strobe width", last_we_len, 2);
    check("R2 address cycle", obs.pop_front(), 32'h105);

    // R4 read request, value ignored
    hwrite(REG_IST, 8'h1F);
    nd_din = 8'h3C;
    hwrite(REG_RREQ, 8'hAB); wait_idle();
    check("R4 read strobe width", last_re_len, 3);
    hread(REG_RDAT, v); check("R4 read byte", v, 8'h3C);
    hread(REG_IST, v);  check("R4 ready flag", v[3], 1'b1);
    check("R4 no write strobe", obs.size(), 0);

    // R8 write-1-to-clear
    hwrite(REG_IST, 8'h00);
    hread(REG_IST, v); check("R8 zero write keeps flag", v[3], 1'b1);
    hwrite(REG_IST, 8'h08);
    hread(REG_IST, v); check("R8 one write clears flag", v[3], 1'b0);

    // R5 fill, full and overflow; R3 ordering; R6 drain edge
    hwrite(REG_CTRL, 8'hFF);
    hwrite(REG_IST, 8'h1F);
    for (int i = 0; i < 6; i++) hwrite(REG_WDAT, 8'hA0 + 8'(i));
    hread(REG_STAT, v); check("R5 full bit", v[1], 1'b1);
    hread(REG_IST, v);  check("R5 overflow flag", v[1], 1'b1);
    wait_idle();
    check("R3 surviving entry count", obs.size(), 5);
    for (int i = 0; i < 5; i++)
      if (obs.size() > 0) check("R3 data order", obs.pop_front(), 32'h0A0 + i);
    hread(REG_IST, v);  check("R6 drain edge flag", v[2], 1'b1);
    hread(REG_STAT, v); check("R5 empty after drain", v, 8'h11);

    // R7 ready/busy synchronizer and event
    nd_rb = 0; repeat (4) @(negedge clk);
    hwrite(REG_IST, 8'h1F);
    hread(REG_STAT, v); check("R7 busy seen", v[0], 1'b0);
    nd_rb = 1;
    @(negedge clk); hread(REG_STAT, v); check("R7 one flop not yet", v[0], 1'b0);
    @(negedge clk); hread(REG_STAT, v); check("R7 two flops", v[0], 1'b1);
    hread(REG_IST, v); check("R7 event not yet", v[0], 1'b0);
    @(negedge clk); hread(REG_IST, v); check("R7 rising event", v[0], 1'b1);

    // R9 page write with R10 counter reset part way
    hwrite(REG_CTRL, 8'h00);
    hwrite(REG_IST, 8'h1F);
    hwrite(REG_PAGE, 8'h02);
    hread(REG_STAT, v); check("R9 write pending set", v[2], 1'b1);
    hwrite(REG_WDAT, 8'h11); hwrite(REG_WDAT, 8'h12); wait_idle();
    hread(REG_STAT, v); check("R9 pending after two", v[2], 1'b1);
    hwrite(REG_RST, 8'h01);
    hread(REG_RST, v); check("R10 reset bit busy", v[0], 1'b1);
    @(negedge clk);
    hread(REG_RST, v); check("R10 reset bit done", v[0], 1'b0);
    hwrite(REG_WDAT, 8'h13); hwrite(REG_WDAT, 8'h14); wait_idle();
    hread(REG_STAT, v); check("R10 counter was cleared", v[2], 1'b1);
    hread(REG_IST, v);  check("R10 no done yet", v[4], 1'b0);
    hwrite(REG_WDAT, 8'h15); wait_idle();
    hread(REG_STAT, v); check("R9 write pending cleared", v[2], 1'b0);
    hread(REG_IST, v);  check("R9 write done flag", v[4], 1'b1);

    // R9 page read
    hwrite(REG_PAGE, 8'h01);
    hread(REG_STAT, v); check("R9 read pending set", v[3], 1'b1);
    nd_din = 8'h5A;
    hwrite(REG_RREQ, 8'h00); hwrite(REG_RREQ, 8'hFF); wait_idle();
    hread(REG_STAT, v); check("R9 read pending after two", v[3], 1'b1);
    nd_din = 8'hC3;
    hwrite(REG_RREQ, 8'h00); wait_idle();
    hread(REG_STAT, v); check("R9 read pending cleared", v[3], 1'b0);
    hread(REG_RDAT, v); check("R4 last read byte", v, 8'hC3);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule